// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs after a program or erase command has been written to a flash target on the low-pin-count host bus. It works out when the target has finished its internal operation. A single start pulse hands it a byte address. The block then issues one-byte memory reads to that address, one after another, through the host bus controller. While the target is busy, one data bit (bit 6) flips on every read. Once that bit returns the same value on two reads in a row, the operation has finished.

The first read only records the flag bit. Every later read compares its flag bit with the value from the read before it. A match gives a one-cycle `done` pulse. If the number of completed reads reaches the programmed limit without a match, the block gives a one-cycle `timeout` pulse and stops polling. The read interface has three parts: a one-cycle request carrying the address, a one-cycle completion pulse, and the returned byte. The block issues a new request only after the previous read has completed.

Top module: `tbit_poller`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `rd_req`, `done` and `timeout` are all 0.
- R2: A `start` seen while idle latches `poll_addr` and `max_polls`. In the next cycle `rd_req` is 1 for exactly one cycle, and `rd_addr` equals the latched address.
- R3: Only one read is outstanding at a time. After a read that does not end the job, `rd_req` pulses in the cycle right after its `rd_done`. It stays 0 while the block waits for `rd_done`.
- R4: Only bit 6 of `rd_data` is examined. The other seven bits have no effect on the outcome.
- R5: The first read of a job never ends it with `done`. A later read whose bit 6 equals the previous read's bit 6 makes `done` 1 for one cycle, in the cycle after that `rd_done`. In that same cycle `busy` is 0.
- R6: While bit 6 alternates from read to read and the limit has not been reached, polling continues with no `done` and no `timeout`.
- R7: When the count of completed reads reaches `max_polls` without a match, `timeout` is 1 for one cycle, in the cycle after that `rd_done`, and polling stops. A `max_polls` of 0 or 1 times out after the first read. A match on the limiting read gives `done`, not `timeout`.
- R8: A `start` that arrives while `busy` is 1 is ignored. `rd_addr` keeps the address of the running job, and no extra request is issued.
- R9: A `rd_done` that arrives when no read is outstanding is ignored: no pulse and no request follow it.
- R10: `done` and `timeout` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a polling job |
| poll_addr | input | ADDR_W | Byte address to poll |
| max_polls | input | CNT_W | Largest number of reads before timeout |
| rd_req | output | 1 | One-cycle read request to the bus controller |
| rd_addr | output | ADDR_W | Address of the requested read |
| rd_done | input | 1 | One-cycle pulse: read finished, `rd_data` valid |
| rd_data | input | DATA_W | Byte returned by the read |
| busy | output | 1 | A polling job is running |
| done | output | 1 | One-cycle pulse: flag bit settled |
| timeout | output | 1 | One-cycle pulse: read limit reached without settling |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- **Settling on the second read.** A design that compares the first read against a reset value would end a job with `done` one read too early.
- **Flag bit steady while the other bits differ.** A design that compares the whole byte would keep polling.
- **Match on the limiting read.** This checks that `done` wins; a design with the wrong priority would raise `timeout`, or both.
- **Limits of 0 and 1.** These catch off-by-one errors in the limit compare.
- **Stray `start` during a job.** A design that reloads its address would show up on `rd_addr` at the next request.
- **Stray `rd_done` while idle.** A design that wrongly accepts it would produce a pulse with no job running.

// File: rtl/tbit_pkg.sv
package tbit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } poll_state_e;

    typedef struct packed {
        logic match;
        logic exhausted;
    } read_verdict_t;

    localparam int DEF_ADDR_W   = 32;
    localparam int DEF_DATA_W   = 8;
    localparam int DEF_FLAG_BIT = 6;
    localparam int DEF_CNT_W    = 16;

    // A read ends the job when it settles or exhausts the budget.
    function automatic logic ends_job(read_verdict_t v);
        return v.match || v.exhausted;
    endfunction

endpackage

// File: rtl/tbit_cmp.sv
module tbit_cmp #(
    parameter int DATA_W   = tbit_pkg::DEF_DATA_W,
    parameter int FLAG_BIT = tbit_pkg::DEF_FLAG_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic [DATA_W-1:0] data,
    output logic              match
);
    logic flag;
    logic prev_q;
    logic have_q;
    logic unused_data_bits;

    assign flag             = data[FLAG_BIT];
    assign unused_data_bits = ^data;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            have_q <= 1'b0;
        end else if (clear) begin
            have_q <= 1'b0;
        end else if (sample) begin
            prev_q <= flag;
            have_q <= 1'b1;
        end
    end

    assign match = sample && have_q && (flag == prev_q);

    // R5
    first_read_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !match);

endmodule

// File: rtl/tbit_cnt.sv
module tbit_cnt #(
    parameter int CNT_W = tbit_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] limit,
    input  logic             step,
    output logic             exhausted
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W:0]   next_cnt;

    assign next_cnt = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            limit_q <= '0;
        end else if (load) begin
            count_q <= '0;
            limit_q <= limit;
        end else if (step && count_q != CNT_MAX) begin
            count_q <= next_cnt[CNT_W-1:0];
        end
    end

    assign exhausted = step && (next_cnt >= {1'b0, limit_q});

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && count_q != CNT_MAX) |=> count_q == $past(count_q) + 1'b1);

endmodule

// File: rtl/tbit_seq.sv
module tbit_seq
    import tbit_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          rd_done,
    input  read_verdict_t verdict,
    output logic          accept,
    output logic          sample,
    output logic          rd_req,
    output logic          busy,
    output logic          done,
    output logic          timeout
);
    poll_state_e state_q, state_d;
    logic done_q, timeout_q;

    assign accept = (state_q == ST_IDLE) && start;
    assign sample = (state_q == ST_WAIT) && rd_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (sample) state_d = ends_job(verdict) ? ST_IDLE : ST_ISSUE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            done_q    <= sample && verdict.match;
            timeout_q <= sample && !verdict.match && verdict.exhausted;
        end
    end

    assign rd_req  = (state_q == ST_ISSUE);
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign timeout = timeout_q;

    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R10
    out_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout));

    // R5
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (done || timeout) |-> !busy);

    // R3
    req_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (sample && !ends_job(verdict)) |=> rd_req);

    // R9
    stray_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !(rd_req || done || timeout));

endmodule

// File: rtl/tbit_poller.sv
module tbit_poller
    import tbit_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int FLAG_BIT = DEF_FLAG_BIT,
    parameter int CNT_W    = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic [CNT_W-1:0]  max_polls,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              timeout
);
    logic          accept;
    logic          sample;
    read_verdict_t verdict;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)         addr_q <= '0;
        else if (accept) addr_q <= poll_addr;
    end
    assign rd_addr = addr_q;

    tbit_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_done (rd_done),
        .verdict (verdict),
        .accept  (accept),
        .sample  (sample),
        .rd_req  (rd_req),
        .busy    (busy),
        .done    (done),
        .timeout (timeout)
    );

    tbit_cmp #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .sample (sample),
        .data   (rd_data),
        .match  (verdict.match)
    );

    tbit_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .limit     (max_polls),
        .step      (sample),
        .exhausted (verdict.exhausted)
    );

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(rd_addr));

endmodule

// File: tb/sim_tbit_poller.sv
`timescale 1ns/1ps
module sim_tbit_poller;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] poll_addr = '0;
    logic [CNT_W-1:0]  max_polls = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_done = 1'b0;
    logic [7:0]        rd_data = '0;
    logic              busy, done, timeout;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    tbit_poller u0 (
        .clk(clk), .rst(rst), .start(start), .poll_addr(poll_addr),
        .max_polls(max_polls), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_done(rd_done), .rd_data(rd_data), .busy(busy),
        .done(done), .timeout(timeout)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected outcome of read i of a job, from the requirements.
    function automatic logic exp_settle(input logic [63:0] b, input int i);
        return (i > 0) && (b[i] == b[i-1]);
    endfunction

    function automatic logic exp_limit(input logic [63:0] b, input int i, input int maxp);
        return !exp_settle(b, i) && (i + 1 >= maxp);
    endfunction

    // mode 0: random other bits; mode 1: other bits alternate all-0 / all-1 (R4)
    task automatic run_job(input logic [31:0] addr, input int maxp, input int k,
                           input bit intrude, input int mode);
        logic [63:0] b;
        logic [7:0]  d;
        bit fin;
        int i;
        b[0] = 1'($urandom);
        for (int j = 1; j < 64; j++) b[j] = (j <= k) ? ~b[j-1] : b[j-1];
        poll_addr = addr;
        max_polls = CNT_W'(maxp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_req == 1'b1, "R2 first request", 32'(rd_req), 1);
        chk(rd_addr == addr, "R2 request address", rd_addr, addr);
        fin = 1'b0;
        i = 0;
        while (!fin) begin
            @(negedge clk);
            chk(rd_req == 1'b0, "R2 R3 single request", 32'(rd_req), 0);
            if (intrude && i == 1) begin
                start = 1'b1;
                poll_addr = ~addr;
                @(negedge clk);
                start = 1'b0;
                chk(rd_req == 1'b0, "R8 no extra request", 32'(rd_req), 0);
            end
            repeat ($urandom % 3) begin
                @(negedge clk);
                chk(rd_req == 1'b0, "R3 wait no request", 32'(rd_req), 0);
            end
            d = 8'($urandom);
            if (mode == 1) d = (i % 2 == 1) ? 8'hFF : 8'h00;
            d[6] = b[i];
            rd_data = d;
            rd_done = 1'b1;
            @(negedge clk);
            rd_done = 1'b0;
            rd_data = 8'($urandom);
            chk(done == exp_settle(b, i), (mode == 1) ? "R4 R5 done" : "R5 R6 done",
                32'(done), 32'(exp_settle(b, i)));
            chk(timeout == exp_limit(b, i, maxp), "R7 timeout",
                32'(timeout), 32'(exp_limit(b, i, maxp)));
            chk(!(done && timeout), "R10 exclusive", 32'(done && timeout), 0);
            if (exp_settle(b, i) || exp_limit(b, i, maxp)) begin
                fin = 1'b1;
                chk(busy == 1'b0, "R5 idle after end", 32'(busy), 0);
            end else begin
                chk(rd_req == 1'b1, "R3 R6 next request", 32'(rd_req), 1);
                chk(rd_addr == addr, "R8 address kept", rd_addr, addr);
                i++;
            end
        end
        @(negedge clk);
        chk(!done && !timeout, "R5 R7 single pulse", {30'd0, done, timeout}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1));
        repeat (3) @(negedge clk);
        chk({busy, rd_req, done, timeout} == 4'b0, "R1 in reset",
            {28'd0, busy, rd_req, done, timeout}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, rd_req, done, timeout} == 4'b0, "R1 after reset",
            {28'd0, busy, rd_req, done, timeout}, 0);

        run_job(32'h000F_0010, 10, 0, 1'b0, 1);   // R4: flag steady, others flip
        run_job(32'h000A_5555, 20, 4, 1'b0, 0);   // R6: several toggles
        run_job(32'h0001_0000, 0, 5, 1'b0, 0);    // R7: limit 0
        run_job(32'h0001_0001, 1, 5, 1'b0, 0);    // R7: limit 1
        run_job(32'h0002_0000, 3, 6, 1'b0, 0);    // R7: limit 3 no settle
        run_job(32'h0003_0000, 3, 1, 1'b0, 0);    // R7: match on limiting read
        run_job(32'h0004_0000, 50, 3, 1'b1, 0);   // R8: start while busy
        run_job(32'h0005_0000, 1000, 40, 1'b0, 0); // R6: long toggle run

        // R9: stray completion while idle
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        chk({busy, rd_req, done, timeout} == 4'b0, "R9 stray rd_done",
            {28'd0, busy, rd_req, done, timeout}, 0);
        @(negedge clk);
        chk({busy, rd_req, done, timeout} == 4'b0, "R9 stray rd_done later",
            {28'd0, busy, rd_req, done, timeout}, 0);

        for (int n = 0; n < 40; n++) begin
            run_job($urandom, int'($urandom % 12), int'($urandom % 9),
                    1'($urandom % 4 == 0), int'($urandom % 2));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule